// File: doc/BRIEF.md
# Shadow-Banked Integer Register File

A 64-bit integer register file with two combinational read ports and one synchronous write port. Indices are 5 bits wide. Index 31 is a hard zero. Indices 0 to 30 are general registers.

A privileged-mode input selects an alternate view. While it is high, eight index values no longer reach the main bank. They reach a private bank of eight shadow registers instead:
- indices 8 through 14 go to shadow slots 0 through 6;
- index 25 goes to shadow slot 7.

Privileged firmware can therefore use scratch registers without saving the interrupted program's values. Every other index behaves the same in both modes. Both read ports and the write port resolve their indices through the same privileged-mode value.

Top module: `banked_gpr_file`

## Requirements
- R1: After reset, every register in the main bank and the shadow bank reads as zero, in both modes.
- R2: With `priv_mode` low, a write to index n (0 to 30) is read back from index n on the next cycle. Every index in this mode addresses the main bank.
- R3: With `priv_mode` high, indices 8 to 14 address shadow slots 0 to 6 in that order. Writes through them leave the main-bank registers 8 to 14 unchanged. Main-bank writes to those indices are not visible through them in this mode.
- R4: With `priv_mode` high, index 25 addresses shadow slot 7. This slot is separate from both main register 25 and the slots used by indices 8 to 14.
- R5: With `priv_mode` high, all indices outside 8 to 14 and 25 address the same main-bank registers as in normal mode.
- R6: Index 31 always reads as zero on both ports. A write to it is discarded in both modes.
- R7: Read port A, read port B and the write port all apply the same remapping, driven by the current `priv_mode`.
- R8: A read of the register being written in the same cycle returns the value held before that write. The new value appears on the following cycle.
- R9: While `wr_en` is low, no register changes, whatever `wr_idx` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is expected to be synchronous to clk |
| priv_mode | input | 1 | High selects the shadow view for the remapped indices |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 64 | Read port A data, combinational |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 64 | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 64 | Write data |

## Verification
A write and a read of the same index can fall in the same cycle. So can a write through the shadow view and a read of the main-bank register with the same number.

The bench provokes the first case by presenting the write and the matching read index in one clock-low phase. The read must still show the old value. After the edge it must show the new one.

The second case is provoked by writing in privileged mode to a remapped index, then dropping `priv_mode` and reading that index on the other port. The result is judged against a bench-side model with separate main and shadow arrays.

// File: rtl/bgpr_pkg.sv
package bgpr_pkg;
  localparam int XLEN        = 64;
  localparam int IDX_W       = 5;
  localparam int NUM_ARCH    = 31;
  localparam int ZERO_IDX    = 31;
  localparam int SH_DEPTH    = 8;
  localparam int SH_LO       = 8;
  localparam int SH_HI       = 14;
  localparam int SH_ALT      = 25;
  localparam int SH_ALT_SLOT = SH_HI - SH_LO + 1;
  localparam int SH_AW       = $clog2(SH_DEPTH);
  localparam int MAIN_AW     = $clog2(NUM_ARCH);
  localparam int NRD         = 2;

  typedef struct packed {
    logic             zero;
    logic             shadow;
    logic [SH_AW-1:0] slot;
  } route_t;
endpackage

// File: rtl/bgpr_map.sv
module bgpr_map
  import bgpr_pkg::*;
(
  input  logic             priv,
  input  logic [IDX_W-1:0] idx,
  output route_t           rt
);
  logic in_run;
  logic is_alt;

  always_comb begin
    in_run    = (idx >= IDX_W'(SH_LO)) && (idx <= IDX_W'(SH_HI));
    is_alt    = (idx == IDX_W'(SH_ALT));
    rt.zero   = (idx == IDX_W'(ZERO_IDX));
    rt.shadow = priv && (in_run || is_alt);
    rt.slot   = is_alt ? SH_AW'(SH_ALT_SLOT) : SH_AW'(idx - IDX_W'(SH_LO));
  end
endmodule

// File: rtl/bgpr_bank.sv
module bgpr_bank #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 64,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [WIDTH-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] ent_en;

  // next-state: per-entry clock enable
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_en[i] = we && (waddr == AW'(i));
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_en[i]) mem_q[i] <= wdata;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      rdata[p] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (raddr[p] == AW'(i)) rdata[p] = mem_q[i];
      end
    end
  end
endmodule

// File: rtl/banked_gpr_file.sv
module banked_gpr_file
  import bgpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             priv_mode,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [XLEN-1:0]  rd_b_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data
);
  logic [NRD-1:0][IDX_W-1:0]   rd_idx;
  route_t                      rt_rd [NRD];
  route_t                      rt_wr;
  logic [NRD-1:0][MAIN_AW-1:0] main_ra;
  logic [NRD-1:0][SH_AW-1:0]   sh_ra;
  logic [NRD-1:0][XLEN-1:0]    main_rd;
  logic [NRD-1:0][XLEN-1:0]    sh_rd;
  logic [NRD-1:0][XLEN-1:0]    rd_out;
  logic                        main_we;
  logic                        sh_we;

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  for (genvar p = 0; p < NRD; p++) begin : g_port
    bgpr_map u_map (.priv(priv_mode), .idx(rd_idx[p]), .rt(rt_rd[p]));
    assign main_ra[p] = MAIN_AW'(rd_idx[p]);
    assign sh_ra[p]   = rt_rd[p].slot;
    always_comb begin
      if (rt_rd[p].zero)        rd_out[p] = '0;
      else if (rt_rd[p].shadow) rd_out[p] = sh_rd[p];
      else                      rd_out[p] = main_rd[p];
    end
  end

  bgpr_map u_wmap (.priv(priv_mode), .idx(wr_idx), .rt(rt_wr));

  assign main_we = wr_en && !rt_wr.zero && !rt_wr.shadow;
  assign sh_we   = wr_en && rt_wr.shadow;

  bgpr_bank #(.DEPTH(NUM_ARCH), .WIDTH(XLEN), .NRD(NRD)) u_main (
    .clk(clk), .rst_n(rst_n), .we(main_we), .waddr(MAIN_AW'(wr_idx)),
    .wdata(wr_data), .raddr(main_ra), .rdata(main_rd)
  );

  bgpr_bank #(.DEPTH(SH_DEPTH), .WIDTH(XLEN), .NRD(NRD)) u_shadow (
    .clk(clk), .rst_n(rst_n), .we(sh_we), .waddr(rt_wr.slot),
    .wdata(wr_data), .raddr(sh_ra), .rdata(sh_rd)
  );

  assign rd_a_data = rd_out[0];
  assign rd_b_data = rd_out[1];
endmodule

// File: rtl/bgpr_chk.sv
module bgpr_chk
  import bgpr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             priv_mode,
  input logic [IDX_W-1:0] rd_a_idx,
  input logic [XLEN-1:0]  rd_a_data,
  input logic [IDX_W-1:0] rd_b_idx,
  input logic [XLEN-1:0]  rd_b_data,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [XLEN-1:0]  wr_data,
  input logic             main_we,
  input logic             sh_we
);
  logic remapped_wr;
  assign remapped_wr = ((wr_idx >= IDX_W'(SH_LO)) && (wr_idx <= IDX_W'(SH_HI)))
                       || (wr_idx == IDX_W'(SH_ALT));

  p_zero_port_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == IDX_W'(ZERO_IDX)) |-> (rd_a_data == '0));

  p_zero_port_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == IDX_W'(ZERO_IDX)) |-> (rd_b_data == '0));

  p_zero_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx == IDX_W'(ZERO_IDX)) |-> (!main_we && !sh_we));

  p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != IDX_W'(ZERO_IDX)) |=>
      (!(rd_a_idx == $past(wr_idx) && priv_mode == $past(priv_mode))
       || rd_a_data == $past(wr_data)));

  p_shadow_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_mode && remapped_wr) |-> !main_we);

  p_normal_main_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_mode || !remapped_wr) |-> !sh_we);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (!main_we && !sh_we));
endmodule

bind banked_gpr_file bgpr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .main_we(main_we), .sh_we(sh_we)
);

// File: tb/tb_banked_gpr_file.sv
module tb_banked_gpr_file;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_mode = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0] m_main [32];
  logic [63:0] m_sh   [8];

  banked_gpr_file dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Model from R2..R6: returns 1 when idx hits the shadow bank, slot in s
  function automatic bit is_sh(input bit pv, input int idx, output int s);
    s = 0;
    if (pv && idx >= 8 && idx <= 14) begin s = idx - 8; return 1; end
    if (pv && idx == 25) begin s = 7; return 1; end
    return 0;
  endfunction

  function automatic logic [63:0] model_rd(input bit pv, input int idx);
    int s;
    if (idx == 31) return '0;
    if (is_sh(pv, idx, s)) return m_sh[s];
    return m_main[idx];
  endfunction

  task automatic model_wr(input bit pv, input int idx, input logic [63:0] d);
    int s;
    if (idx == 31) return;
    if (is_sh(pv, idx, s)) m_sh[s] = d;
    else m_main[idx] = d;
  endtask

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // commits at the posedge between two negedges
  task automatic do_write(input bit pv, input int idx, input logic [63:0] d);
    @(negedge clk);
    priv_mode = pv; wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(pv, idx, d);
  endtask

  task automatic read_check(input string req, input bit pv, input int ia, input int ib);
    priv_mode = pv; rd_a_idx = 5'(ia); rd_b_idx = 5'(ib);
    #1;
    check(req, rd_a_data, model_rd(pv, ia));
    check(req, rd_b_data, model_rd(pv, ib));
  endtask

  task automatic t_reset_r1;
    for (int i = 0; i < 32; i++) begin
      check("R1", model_rd(0, i), 64'h0);
      read_check("R1", 0, i, 31 - i);
      read_check("R1", 1, i, 31 - i);
    end
  endtask

  task automatic t_normal_r2;
    for (int i = 0; i < 31; i++) do_write(0, i, 64'hA000_0000_0000_0000 | 64'(i * 3 + 1));
    for (int i = 0; i < 31; i++) read_check("R2", 0, i, 30 - i);
  endtask

  task automatic t_shadow_r3_r4;
    for (int i = 8; i <= 14; i++) do_write(1, i, 64'h5000_0000_0000_0000 | 64'(i));
    do_write(1, 25, 64'h5A5A_2525_5A5A_2525);
    for (int i = 8; i <= 14; i++) begin
      read_check("R3", 1, i, 25);
      read_check("R3", 0, i, i);
    end
    read_check("R4", 1, 25, 8);
    read_check("R4", 0, 25, 25);
    // main write while normal must not show through the shadow view
    do_write(0, 12, 64'hDEAD_0000_0000_0012);
    read_check("R3", 1, 12, 12);
    read_check("R3", 0, 12, 12);
  endtask

  task automatic t_shared_r5;
    do_write(1, 3,  64'h1111_2222_3333_0003);
    do_write(1, 20, 64'h1111_2222_3333_0020);
    do_write(1, 15, 64'h1111_2222_3333_0015);
    do_write(1, 7,  64'h1111_2222_3333_0007);
    read_check("R5", 0, 3, 20);
    read_check("R5", 0, 15, 7);
    read_check("R5", 1, 24, 26);
  endtask

  task automatic t_zero_r6;
    do_write(0, 31, 64'hFFFF_FFFF_FFFF_FFFF);
    read_check("R6", 0, 31, 31);
    do_write(1, 31, 64'hFFFF_FFFF_FFFF_FFFF);
    read_check("R6", 1, 31, 31);
    check("R6", rd_a_data, 64'h0);
  endtask

  task automatic t_ports_r7;
    // write through priv view, read on port B in both views
    do_write(1, 9, 64'hB0B0_0000_0000_0009);
    priv_mode = 1'b1; rd_a_idx = 5'd0; rd_b_idx = 5'd9; #1;
    check("R7", rd_b_data, 64'hB0B0_0000_0000_0009);
    priv_mode = 1'b0; #1;
    check("R7", rd_b_data, m_main[9]);
  endtask

  task automatic t_rdw_r8;
    logic [63:0] old_a, old_b;
    @(negedge clk);
    old_a = model_rd(0, 5);
    priv_mode = 1'b0; wr_en = 1'b1; wr_idx = 5'd5; wr_data = 64'hC0FF_EE00_0000_0005;
    rd_a_idx = 5'd5; rd_b_idx = 5'd5; #1;
    check("R8", rd_a_data, old_a);
    check("R8", rd_b_data, old_a);
    @(negedge clk);
    wr_en = 1'b0; model_wr(0, 5, 64'hC0FF_EE00_0000_0005); #1;
    check("R8", rd_a_data, 64'hC0FF_EE00_0000_0005);
    // same in priv mode on a shadow slot
    old_b = model_rd(1, 10);
    priv_mode = 1'b1; wr_en = 1'b1; wr_idx = 5'd10; wr_data = 64'hC0FF_EE00_0000_0010;
    rd_b_idx = 5'd10; #1;
    check("R8", rd_b_data, old_b);
    @(negedge clk);
    wr_en = 1'b0; model_wr(1, 10, 64'hC0FF_EE00_0000_0010); #1;
    check("R8", rd_b_data, 64'hC0FF_EE00_0000_0010);
  endtask

  task automatic t_idle_r9;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      priv_mode = k[0]; wr_en = 1'b0; wr_idx = 5'(k * 5); wr_data = 64'h9999_0000_0000_0000 | 64'(k);
    end
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      read_check("R9", 0, i, i);
      read_check("R9", 1, i, i);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 32; i++) m_main[i] = '0;
    for (int i = 0; i < 8; i++) m_sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_normal_r2();
    t_shadow_r3_r4();
    t_shared_r5();
    t_zero_r6();
    t_ports_r7();
    t_rdw_r8();
    t_idle_r9();
    finish_up();
  end
endmodule